// File: doc/BRIEF.md
# Reset Output Pulse Generator

This block produces the chip's active-low reset-output pin, a core reset and a reset for the SDRAM controller. Three things can start a reset: a low level on the external reset input, a one-cycle soft-reset request from the register file, and a one-cycle watchdog-timeout pulse. A soft reset produces a short pulse. A watchdog timeout or an external reset produces a long pulse. The block runs on the CPU clock.

A static strap input decides whether an external reset also reaches the SDRAM controller. With the strap low, the board can be reset while SDRAM refresh keeps running, so memory contents survive a debug reset. Soft resets and watchdog resets never reset the SDRAM controller.

The external reset input is brought into the clock domain through two flip-flops. The long count begins only after the synchronized input has returned high. A long cause that arrives during a short pulse reloads the counter with the long length. A soft request never shortens a pulse that is already running.

Top module: `rst_pulse_gen`

## Requirements
- R1: When no pulse is active, a one-cycle `soft_req` drives `rst_out_n` low from the following cycle for exactly SHORT_LEN (128) cycles.
- R2: A one-cycle `wdog_tmo` drives `rst_out_n` low from the following cycle for exactly LONG_LEN (32768) cycles.
- R3: `ext_rst_n` passes through a two-flip-flop synchronizer. The pin goes low two cycles after the input falls. After the synchronized input rises, the pin stays low for exactly LONG_LEN further cycles.
- R4: With `sdram_strap` = 1, `sdram_rst` is 1 for the whole low interval caused by the external reset.
- R5: With `sdram_strap` = 0, `sdram_rst` stays 0 during an external reset.
- R6: A soft reset or a watchdog reset never asserts `sdram_rst`.
- R7: A watchdog timeout that arrives during a short pulse reloads the counter. The pin stays low for LONG_LEN cycles after the timeout.
- R8: A `soft_req` that arrives while a pulse is active has no effect on the pulse's remaining length.
- R9: `core_rst` is always the inverse of `rst_out_n`.
- R10: After `rst`, the block is idle: `rst_out_n` = 1, `core_rst` = 0, `sdram_rst` = 0.
- R11: While the synchronized external reset is low, `rst_out_n` is held low, whatever the counter value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high power-on reset of the block |
| ext_rst_n | input | 1 | Asynchronous external reset input, active low |
| soft_req | input | 1 | One-cycle soft-reset request |
| wdog_tmo | input | 1 | One-cycle watchdog timeout pulse |
| sdram_strap | input | 1 | Static strap: 1 lets the external reset also reset the SDRAM controller |
| rst_out_n | output | 1 | Reset-output pin, active low |
| core_rst | output | 1 | Core reset, active high, same interval as the pin |
| sdram_rst | output | 1 | SDRAM-controller reset, active high |

## Verification
The hardest case to produce from the ports is a long cause that overlaps a short pulse already in progress. The bench counts low cycles of the pin from the first low sample. It injects `wdog_tmo` at a known count (sample 50), so the expected total is 50 plus the long length. The bench uses the same counting method to place a second soft request inside a running short pulse. For the external reset, it accounts for the two synchronizer stages and checks the SDRAM reset cycle by cycle under both strap values.

// File: rtl/rpg_pkg.sv
package rpg_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_SOFT = 2'd1,
        CAUSE_WDOG = 2'd2,
        CAUSE_EXT  = 2'd3
    } cause_t;

    // Counter width able to hold the value n.
    function automatic int cnt_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rpg_sync.sv
module rpg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/rpg_counter.sv
module rpg_counter
    import rpg_pkg::*;
#(
    parameter int SHORT_LEN = 128,
    parameter int LONG_LEN  = 32768,
    localparam int CW = cnt_width(LONG_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ext_low,
    input  logic          wdog_tmo,
    input  logic          soft_req,
    output logic [CW-1:0] cnt,
    output cause_t        cause,
    output logic          busy
);
    localparam logic [CW-1:0] SHORT_V = CW'(SHORT_LEN);
    localparam logic [CW-1:0] LONG_V  = CW'(LONG_LEN);

    assign busy = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            cause <= CAUSE_NONE;
        end else if (ext_low) begin
            cnt   <= LONG_V;
            cause <= CAUSE_EXT;
        end else if (wdog_tmo) begin
            cnt   <= LONG_V;
            cause <= CAUSE_WDOG;
        end else if (soft_req && !busy) begin
            cnt   <= SHORT_V;
            cause <= CAUSE_SOFT;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
            if (cnt == CW'(1)) cause <= CAUSE_NONE;
        end
    end
endmodule

// File: rtl/rpg_outputs.sv
module rpg_outputs
    import rpg_pkg::*;
(
    input  logic   ext_low,
    input  logic   busy,
    input  cause_t cause,
    input  logic   sdram_strap,
    output logic   rst_out_n,
    output logic   core_rst,
    output logic   sdram_rst
);
    logic active;

    always_comb begin
        active    = ext_low || busy;
        rst_out_n = !active;
        core_rst  = active;
        sdram_rst = sdram_strap && (ext_low || (busy && cause == CAUSE_EXT));
    end
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen
    import rpg_pkg::*;
#(
    parameter int SHORT_LEN = 128,
    parameter int LONG_LEN  = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_rst_n,
    input  logic soft_req,
    input  logic wdog_tmo,
    input  logic sdram_strap,
    output logic rst_out_n,
    output logic core_rst,
    output logic sdram_rst
);
    localparam int CW = cnt_width(LONG_LEN);

    logic          ext_sync;
    logic          ext_low;
    logic [CW-1:0] cnt;
    cause_t        cause;
    logic          busy;

    rpg_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (ext_rst_n),
        .sync_out (ext_sync)
    );

    assign ext_low = !ext_sync;

    rpg_counter #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .ext_low  (ext_low),
        .wdog_tmo (wdog_tmo),
        .soft_req (soft_req),
        .cnt      (cnt),
        .cause    (cause),
        .busy     (busy)
    );

    rpg_outputs u_out (
        .ext_low     (ext_low),
        .busy        (busy),
        .cause       (cause),
        .sdram_strap (sdram_strap),
        .rst_out_n   (rst_out_n),
        .core_rst    (core_rst),
        .sdram_rst   (sdram_rst)
    );
endmodule

// File: rtl/rpg_chk.sv
module rpg_chk #(
    parameter int SHORT_LEN = 128,
    parameter int LONG_LEN  = 32768,
    parameter int CW        = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          soft_req,
    input logic          wdog_tmo,
    input logic          sdram_strap,
    input logic          rst_out_n,
    input logic          core_rst,
    input logic          sdram_rst,
    input logic          ext_low,
    input logic          busy,
    input logic [CW-1:0] cnt
);
    AST_SOFT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (soft_req && !busy && !ext_low && !wdog_tmo) |=> (cnt == CW'(SHORT_LEN))); // R1

    AST_LONG_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wdog_tmo || ext_low) |=> (cnt == CW'(LONG_LEN))); // R7

    AST_SOFT_NO_SHORTEN: assert property (@(posedge clk) disable iff (rst)
        (busy && soft_req && !ext_low && !wdog_tmo) |=> (cnt == CW'($past(cnt) - 1'b1))); // R8

    AST_EXT_HOLDS_PIN: assert property (@(posedge clk) disable iff (rst)
        ext_low |-> !rst_out_n); // R11

    AST_CORE_TRACKS_PIN: assert property (@(posedge clk) disable iff (rst)
        core_rst != rst_out_n); // R9

    AST_STRAP_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        !sdram_strap |-> !sdram_rst); // R5

    AST_SDRAM_INSIDE_PULSE: assert property (@(posedge clk) disable iff (rst)
        sdram_rst |-> !rst_out_n); // R4
endmodule

bind rst_pulse_gen rpg_chk #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN), .CW(CW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .soft_req    (soft_req),
    .wdog_tmo    (wdog_tmo),
    .sdram_strap (sdram_strap),
    .rst_out_n   (rst_out_n),
    .core_rst    (core_rst),
    .sdram_rst   (sdram_rst),
    .ext_low     (ext_low),
    .busy        (busy),
    .cnt         (cnt)
);

// File: tb/rst_pulse_gen_tb.sv
module rst_pulse_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SHORT_LEN  = 128;
    localparam int LONG_LEN   = 32768;
    localparam int WD_CYCLES  = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_rst_n = 1'b1;
    logic soft_req = 1'b0;
    logic wdog_tmo = 1'b0;
    logic sdram_strap = 1'b0;
    logic rst_out_n, core_rst, sdram_rst;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_pulse_gen #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_dut (
        .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .soft_req(soft_req),
        .wdog_tmo(wdog_tmo), .sdram_strap(sdram_strap),
        .rst_out_n(rst_out_n), .core_rst(core_rst), .sdram_rst(sdram_rst)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count low samples of the pin from the current negedge; track side outputs.
    task automatic count_low(input bit exp_sdram, inout int n, inout int bad_core, inout int bad_sdram);
        while (!rst_out_n && n < 40000) begin
            if (core_rst != 1'b1) bad_core++;
            if (sdram_rst != exp_sdram) bad_sdram++;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset_state();
        check(rst_out_n == 1'b1, "R10 rst_out_n", rst_out_n, 1);
        check(core_rst == 1'b0, "R10 core_rst", core_rst, 0);
        check(sdram_rst == 1'b0, "R10 sdram_rst", sdram_rst, 0);
    endtask

    task automatic t_soft();
        int n = 0, bc = 0, bs = 0;
        sdram_strap = 1'b1;
        soft_req = 1'b1;
        @(negedge clk);
        soft_req = 1'b0;
        count_low(1'b0, n, bc, bs);
        check(n == SHORT_LEN, "R1 soft pulse length", n, SHORT_LEN);
        check(bc == 0, "R9 core during soft", bc, 0);
        check(bs == 0, "R6 sdram during soft", bs, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_soft_ignored();
        int n = 0, bc = 0, bs = 0;
        soft_req = 1'b1;
        @(negedge clk);
        soft_req = 1'b0;
        repeat (40) begin n++; @(negedge clk); end
        soft_req = 1'b1;
        n++;
        @(negedge clk);
        soft_req = 1'b0;
        count_low(1'b0, n, bc, bs);
        check(n == SHORT_LEN, "R8 second soft ignored", n, SHORT_LEN);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_wdog();
        int n = 0, bc = 0, bs = 0;
        wdog_tmo = 1'b1;
        @(negedge clk);
        wdog_tmo = 1'b0;
        count_low(1'b0, n, bc, bs);
        check(n == LONG_LEN, "R2 watchdog pulse length", n, LONG_LEN);
        check(bc == 0, "R9 core during watchdog", bc, 0);
        check(bs == 0, "R6 sdram during watchdog", bs, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_preempt();
        int n = 0, bc = 0, bs = 0;
        soft_req = 1'b1;
        @(negedge clk);
        soft_req = 1'b0;
        repeat (49) begin n++; @(negedge clk); end
        wdog_tmo = 1'b1;
        n++;
        @(negedge clk);
        wdog_tmo = 1'b0;
        count_low(1'b0, n, bc, bs);
        check(n == 50 + LONG_LEN, "R7 watchdog reloads short pulse", n, 50 + LONG_LEN);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_ext(input bit strap);
        int n = 0, bc = 0, bs = 0, held = 0;
        localparam int H = 10;
        sdram_strap = strap;
        ext_rst_n = 1'b0;
        @(negedge clk);
        check(rst_out_n == 1'b1, "R3 one stage of latency", rst_out_n, 1);
        @(negedge clk);
        repeat (H - 2) begin
            if (rst_out_n) held++;
            if (sdram_rst != strap) bs++;
            n++;
            @(negedge clk);
        end
        check(held == 0, "R11 pin low while input low", held, 0);
        ext_rst_n = 1'b1;
        count_low(strap, n, bc, bs);
        check(n == H + LONG_LEN, "R3 external pulse length", n, H + LONG_LEN);
        check(bc == 0, "R9 core during external", bc, 0);
        if (strap) check(bs == 0, "R4 sdram follows external", bs, 0);
        else       check(bs == 0, "R5 sdram blocked by strap", bs, 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_soft();
        t_soft_ignored();
        t_wdog();
        t_preempt();
        t_ext(1'b1);
        t_ext(1'b0);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule